// File: doc/BRIEF.md
# Iterative Accumulate-Multiply Loop Engine

This block evaluates a bounded loop in hardware with a small controller and a datapath. A start pulse captures an unsigned operand X. The block then sets a running sum to zero and a running product to one. While the product stays below a fixed limit (100000 by default), each pass adds X to the sum and then multiplies the product by the new sum. The add and the multiply each take one clock cycle, in separate states, and a test state between passes compares the product with the limit.

When the loop ends, the block gives a one-cycle done pulse and holds the final sum and product on its outputs until the next start. If X is zero the product could never reach the limit, so the block flags an error and finishes at once. The product register saturates at its all-ones value instead of wrapping. A start that arrives while the loop is running is ignored.

Top module: `loop_accmul`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle and after that edge `done`, `err`, `r2_out` and `ac_out` all read zero. This holds even when reset arrives in the middle of a run.
- R2: A `start` sampled high while the block is idle captures `x_in`, clears the sum to 0 and sets the product to 1.
- R3: Each pass first loads sum = sum + X in one cycle and then loads product = product * sum in the next cycle. The final outputs equal the values that this loop produces.
- R4: The loop keeps running while the product is below LIMIT and stops at the first test where the product is at least LIMIT. A normal finish therefore has `ac_out` >= LIMIT.
- R5: With n passes, `done` goes high 3n+2 clock edges after the edge that samples `start`.
- R6: `done` is high for exactly one cycle per run.
- R7: After `done`, `r2_out`, `ac_out` and `err` keep their values until the next accepted start. A `start` that arrives while a run is in progress has no effect on the result.
- R8: With X = 0 the block runs no pass. It raises `done` 2 edges after the start edge with `err` = 1, `r2_out` = 0 and `ac_out` = 1.
- R9: If a product does not fit in ACW bits, the product register loads the all-ones value instead of the wrapped result.
- R10: `err` clears when the next start is accepted, so a later run with nonzero X ends with `err` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run, accepted only when idle |
| x_in | input | XW | Unsigned operand X |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Set when the run ended because X was zero |
| r2_out | output | R2W | Final running sum |
| ac_out | output | ACW | Final running product |

## Verification
The bench picks operands around the loop exit: 223 ends just below the limit after two passes and needs a third, while 224 crosses it after two. A comparator that is off by one or inverted would give one pass too many or too few, and both the outputs and the done latency would be wrong. X = 1 gives the longest run, nine passes, and would expose a controller that skipped or repeated a state. X = 0 checks the error exit, which a naive design would turn into an endless loop. A second instance with a 20-bit product makes the multiply overflow, so a wrapping multiplier would report a small product. The bench also resets in the middle of a run and pulses start while the loop is busy. A design that took the second start or did not clear its state on reset would show it in the held outputs.

// File: rtl/loop_pkg.sv
// Shared controller state encoding for the accumulate-multiply loop engine.
// Assumes the controller and the checker agree on this single enum.
package loop_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_INIT = 3'd1,
        S_TEST = 3'd2,
        S_ADD  = 3'd3,
        S_MUL  = 3'd4,
        S_FIN  = 3'd5
    } state_t;
endpackage

// File: rtl/sat_mul.sv
// Unsigned multiplier that saturates to the all-ones value of the A width.
// Purely combinational; the caller registers the result in one cycle.
// Assumes AW >= 1 and BW >= 1.
module sat_mul #(
    parameter int AW = 64,
    parameter int BW = 32
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [AW-1:0] y
);
    localparam int PW = AW + BW;

    logic [PW-1:0] full;
    logic          ovf;

    // Full-width product, then clamp if any bit above AW is set.
    always_comb begin
        full = PW'(a) * PW'(b);
        ovf  = |full[PW-1:AW];
        y    = ovf ? {AW{1'b1}} : full[AW-1:0];
    end
endmodule

// File: rtl/loop_datapath.sv
// Datapath: operand register R1, sum register R2, product register AC,
// adder, saturating multiplier and the less-than-limit comparator.
// Each register has its own load enable. While ld_r1 is high (init state)
// the sum and product load their start values instead of the unit results.
module loop_datapath #(
    parameter int          XW    = 16,
    parameter int          R2W   = 32,
    parameter int          ACW   = 64,
    parameter int unsigned LIMIT = 100000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [XW-1:0]  x_in,
    input  logic           ld_r1,
    input  logic           ld_r2,
    input  logic           ld_ac,
    output logic           lt,
    output logic           r1_zero,
    output logic [R2W-1:0] r2_q,
    output logic [ACW-1:0] ac_q
);
    localparam logic [ACW-1:0] LIMIT_V = ACW'(LIMIT);

    logic [XW-1:0]  r1_q;
    logic [R2W-1:0] sum;
    logic [ACW-1:0] prod;

    // Adder: the operand is zero-extended to the sum width.
    assign sum = r2_q + R2W'(r1_q);

    sat_mul #(.AW(ACW), .BW(R2W)) u_mul (
        .a (ac_q),
        .b (r2_q),
        .y (prod)
    );

    // Comparator and zero detect that the controller tests.
    assign lt      = (ac_q < LIMIT_V);
    assign r1_zero = (r1_q == '0);

    // Operand register: captured once per run.
    always_ff @(posedge clk) begin
        if (!rst_n)     r1_q <= '0;
        else if (ld_r1) r1_q <= x_in;
    end

    // Sum register: cleared at init, otherwise loads the adder output.
    always_ff @(posedge clk) begin
        if (!rst_n)     r2_q <= '0;
        else if (ld_r2) r2_q <= ld_r1 ? '0 : sum;
    end

    // Product register: set to one at init, otherwise loads the multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n)     ac_q <= '0;
        else if (ld_ac) ac_q <= ld_r1 ? ACW'(1) : prod;
    end
endmodule

// File: rtl/loop_ctrl.sv
// Controller of the loop: idle -> init -> test -> (add -> mul -> test)* -> fin.
// It drives one load enable per register and owns the error flag.
// Assumes lt and r1_zero come from registered datapath state.
module loop_ctrl
    import loop_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   lt,
    input  logic   r1_zero,
    output logic   ld_r1,
    output logic   ld_r2,
    output logic   ld_ac,
    output logic   err_q,
    output state_t state_q
);
    state_t state_d;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state: the test state loops through add and mul or exits.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_INIT;
            S_INIT: state_d = S_TEST;
            S_TEST: begin
                if (!lt || r1_zero) state_d = S_FIN;
                else                state_d = S_ADD;
            end
            S_ADD:  state_d = S_MUL;
            S_MUL:  state_d = S_TEST;
            S_FIN:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Load enables: all three at init, then one per loop-body state.
    assign ld_r1 = (state_q == S_INIT);
    assign ld_r2 = (state_q == S_INIT) || (state_q == S_ADD);
    assign ld_ac = (state_q == S_INIT) || (state_q == S_MUL);

    // Error flag: cleared at init, set when a zero operand would loop forever.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  err_q <= 1'b0;
        else if (state_q == S_INIT)                  err_q <= 1'b0;
        else if (state_q == S_TEST && lt && r1_zero) err_q <= 1'b1;
    end
endmodule

// File: rtl/loop_accmul.sv
// Top of the accumulate-multiply loop engine: controller plus datapath.
// done is decoded from the registered state, so it lasts one cycle.
// Assumes start is synchronous to clk.
module loop_accmul
    import loop_pkg::*;
#(
    parameter int          XW    = 16,
    parameter int          R2W   = 32,
    parameter int          ACW   = 64,
    parameter int unsigned LIMIT = 100000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [XW-1:0]  x_in,
    output logic           done,
    output logic           err,
    output logic [R2W-1:0] r2_out,
    output logic [ACW-1:0] ac_out
);
    logic   ld_r1, ld_r2, ld_ac, lt, r1_zero;
    state_t state_q;

    loop_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .lt      (lt),
        .r1_zero (r1_zero),
        .ld_r1   (ld_r1),
        .ld_r2   (ld_r2),
        .ld_ac   (ld_ac),
        .err_q   (err),
        .state_q (state_q)
    );

    loop_datapath #(.XW(XW), .R2W(R2W), .ACW(ACW), .LIMIT(LIMIT)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_in    (x_in),
        .ld_r1   (ld_r1),
        .ld_r2   (ld_r2),
        .ld_ac   (ld_ac),
        .lt      (lt),
        .r1_zero (r1_zero),
        .r2_q    (r2_out),
        .ac_q    (ac_out)
    );

    // Done pulse comes from the after-loop state.
    assign done = (state_q == S_FIN);
endmodule

// File: rtl/loop_accmul_chk.sv
// Property checker for loop_accmul, attached through bind.
// Observes the ports, the load enables and the controller state.
module loop_accmul_chk
    import loop_pkg::*;
#(
    parameter int          R2W   = 32,
    parameter int          ACW   = 64,
    parameter int unsigned LIMIT = 100000
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           done,
    input logic           err,
    input logic [R2W-1:0] r2_out,
    input logic [ACW-1:0] ac_out,
    input logic           ld_r1,
    input logic           ld_r2,
    input logic           ld_ac,
    input state_t         state_q
);
    localparam logic [ACW-1:0] LIMIT_V = ACW'(LIMIT);

    // R3: the add step is always followed by the multiply step.
    a_r3_add_then_mul: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_r2 && !ld_r1) |=> (ld_ac && !ld_r1));

    // R3: a loop add strictly increases the sum.
    a_r3_sum_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_r2 && !ld_r1) |=> (r2_out > $past(r2_out)));

    // R4: a normal finish leaves the product at or above the limit.
    a_r4_exit_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (ac_out >= LIMIT_V));

    // R6: done is a single-cycle pulse.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: outputs hold while idle and no start is present.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start) |=>
            ($stable(r2_out) && $stable(ac_out) && $stable(err)));

    // R8: an error finish leaves the init values untouched.
    a_r8_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (r2_out == '0 && ac_out == ACW'(1)));
endmodule

bind loop_accmul loop_accmul_chk #(.R2W(R2W), .ACW(ACW), .LIMIT(LIMIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .err     (err),
    .r2_out  (r2_out),
    .ac_out  (ac_out),
    .ld_r1   (ld_r1),
    .ld_r2   (ld_r2),
    .ld_ac   (ld_ac),
    .state_q (state_q)
);

// File: tb/loop_accmul_tb.sv
// Self-checking bench for loop_accmul: a vector table walked by one loop,
// then directed tests for reset, busy start, zero operand and saturation.
module loop_accmul_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_s = 1'b0;
    logic [15:0] x = '0;
    logic        done, err, done_s, err_s;
    logic [31:0] r2, r2_s;
    logic [63:0] ac;
    logic [19:0] ac_s;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    loop_accmul u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .x_in (x),
        .done (done), .err (err), .r2_out (r2), .ac_out (ac)
    );

    // Narrow product register so that the multiply overflows.
    loop_accmul #(.ACW(20)) u_dut_sat (
        .clk (clk), .rst_n (rst_n), .start (start_s), .x_in (x),
        .done (done_s), .err (err_s), .r2_out (r2_s), .ac_out (ac_s)
    );

    localparam int NV = 8;
    localparam logic [15:0] VEC_X [NV] = '{16'd1, 16'd2, 16'd3, 16'd10,
                                           16'd223, 16'd224, 16'd316, 16'd65535};

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference loop taken from the requirements, with saturation at maxv.
    task automatic model(input logic [15:0] xv, input logic [63:0] maxv,
                         output logic [31:0] er2, output logic [63:0] eac,
                         output int n, output bit eerr);
        logic [95:0] p;
        er2 = '0; eac = 64'd1; n = 0; eerr = 1'b0;
        while (eac < 64'd100000 && n < 40) begin
            if (xv == 0) begin
                eerr = 1'b1;
                break;
            end
            er2 = er2 + 32'(xv);
            p   = {32'b0, eac} * {64'b0, er2};
            eac = (p > {32'b0, maxv}) ? maxv : p[63:0];
            n++;
        end
    endtask

    // Pulse start for one cycle, then count edges until done is seen.
    task automatic run(input bit sel, input logic [15:0] xv, output int cyc);
        @(negedge clk);
        x = xv;
        if (sel) start_s = 1'b1; else start = 1'b1;
        @(negedge clk);
        start = 1'b0; start_s = 1'b0;
        cyc = 0;
        while (cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (sel ? done_s : done) break;
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] er2;
        logic [63:0] eac;
        logic [31:0] h2;
        logic [63:0] hac;
        int          n, cyc;
        bit          eerr;

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", 64'(done), 64'd0);
        chk("R1", "err in reset", 64'(err), 64'd0);
        chk("R1", "r2 in reset", 64'(r2), 64'd0);
        chk("R1", "ac in reset", ac, 64'd0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6: vector table.
        for (int i = 0; i < NV; i++) begin
            model(VEC_X[i], 64'hFFFF_FFFF_FFFF_FFFF, er2, eac, n, eerr);
            run(1'b0, VEC_X[i], cyc);
            chk("R5", "latency", 64'(cyc), 64'(3 * n + 2));
            chk("R3", "final sum", 64'(r2), 64'(er2));
            chk("R3", "final product", ac, eac);
            chk("R4", "product at or above limit", 64'(ac >= 64'd100000), 64'd1);
            chk("R2", "no error for nonzero X", 64'(err), 64'd0);
            @(negedge clk);
            chk("R6", "done drops after one cycle", 64'(done), 64'd0);
        end

        // R7: outputs hold after done.
        h2 = r2; hac = ac;
        repeat (6) @(negedge clk);
        chk("R7", "sum held", 64'(r2), 64'(h2));
        chk("R7", "product held", ac, hac);

        // R7: start while busy is ignored.
        model(16'd3, 64'hFFFF_FFFF_FFFF_FFFF, er2, eac, n, eerr);
        @(negedge clk); x = 16'd3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        x = 16'd500; start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk("R7", "busy start ignored, sum", 64'(r2), 64'(er2));
        chk("R7", "busy start ignored, product", ac, eac);

        // R8: zero operand.
        run(1'b0, 16'd0, cyc);
        chk("R8", "zero X latency", 64'(cyc), 64'd2);
        chk("R8", "zero X err", 64'(err), 64'd1);
        chk("R8", "zero X sum", 64'(r2), 64'd0);
        chk("R8", "zero X product", ac, 64'd1);
        repeat (3) @(negedge clk);
        chk("R7", "err held", 64'(err), 64'd1);

        // R10: err clears on the next run.
        run(1'b0, 16'd5, cyc);
        chk("R10", "err cleared", 64'(err), 64'd0);

        // R9: saturation on the 20-bit instance.
        model(16'd65535, 64'hF_FFFF, er2, eac, n, eerr);
        run(1'b1, 16'd65535, cyc);
        chk("R9", "saturated product", 64'(ac_s), 64'hF_FFFF);
        chk("R9", "model agrees", eac, 64'hF_FFFF);
        chk("R9", "sum at saturation", 64'(r2_s), 64'(er2));
        chk("R5", "saturating latency", 64'(cyc), 64'(3 * n + 2));

        // R1: reset in the middle of a run.
        @(negedge clk); x = 16'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid-run reset done", 64'(done), 64'd0);
        chk("R1", "mid-run reset sum", 64'(r2), 64'd0);
        chk("R1", "mid-run reset product", ac, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "stays idle after reset", 64'(done), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule